// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the register-transfer half of a small accumulator machine. Six word registers, a word-addressed RAM and a three-function ALU all meet on one shared bus. An external sequencer drives a vector of thirteen strobes each cycle. Read strobes pick the one source that drives the bus. Write strobes pick which destinations capture the bus value at the next rising clock edge.

Words are `ADDR_W+3` bits wide. The RAM holds `2^ADDR_W` words and is addressed by the low `ADDR_W` bits of the address register. The ALU always combines the argument register with the bus, and the result buffer captures the ALU output on every clock. The only values that leave the block are an accumulator-nonzero flag and the three top bits of the instruction register, which the sequencer uses for branching and decoding.

Top module: `acc_datapath`

## Requirements
- R1: An active-low reset clears the address, program counter, accumulator, instruction, argument and result-buffer registers, so `acc_nz_o` is 0 and `opcode_o` is 0 after reset.
- R2: The bus source is chosen by priority, highest first: RAM, program counter, accumulator, instruction register, result buffer. A lower source is legal only while every higher one is inactive, and a cycle with more than one read strobe is illegal. With no read strobe the bus carries 0.
- R3: The address, program counter, accumulator, instruction and argument registers load the bus value at a rising edge only when their own write strobe is high, and hold otherwise. The address and argument registers cannot drive the bus.
- R4: The RAM is addressed by the low `ADDR_W` bits of the address register, so with `ADDR_W`=5 the addresses 3 and 35 select the same word. It writes the bus value at the edge when `mem_wr_i` is high and leaves the word unchanged otherwise. Its read value is combinational from the current address.
- R5: With `{alu_sub_i, alu_inc_i}` = 2'b00 the ALU output is the argument register plus the bus, modulo 2^(`ADDR_W`+3).
- R6: With `{alu_sub_i, alu_inc_i}` = 2'b01 the ALU output is the bus plus one, modulo 2^(`ADDR_W`+3).
- R7: With `{alu_sub_i, alu_inc_i}` = 2'b10 the ALU output is the argument register minus the bus, modulo 2^(`ADDR_W`+3).
- R8: With `{alu_sub_i, alu_inc_i}` = 2'b11 the ALU output is 0.
- R9: The result buffer loads the ALU output at every rising edge outside reset, whatever the strobes are.
- R10: `opcode_o` equals instruction-register bits [`ADDR_W`+2:`ADDR_W`]. The lower bits do not affect it.
- R11: `acc_nz_o` is high exactly when the accumulator holds a nonzero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_wr_i | input | 1 | Write the bus value into the RAM at the current address |
| mem_rd_i | input | 1 | RAM drives the bus |
| mar_wr_i | input | 1 | Address register loads the bus |
| pc_wr_i | input | 1 | Program counter loads the bus |
| pc_rd_i | input | 1 | Program counter drives the bus |
| acc_wr_i | input | 1 | Accumulator loads the bus |
| acc_rd_i | input | 1 | Accumulator drives the bus |
| ir_wr_i | input | 1 | Instruction register loads the bus |
| ir_rd_i | input | 1 | Instruction register drives the bus |
| arg_wr_i | input | 1 | Argument register loads the bus |
| alu_sub_i | input | 1 | ALU function select, upper bit |
| alu_inc_i | input | 1 | ALU function select, lower bit |
| buf_rd_i | input | 1 | Result buffer drives the bus |
| acc_nz_o | output | 1 | Accumulator is nonzero |
| opcode_o | output | 3 | Top three bits of the instruction register |

## Verification
Two functions can share a cycle. First, a RAM read can feed the instruction register while the same word is written back and the ALU increments it into the result buffer. Second, the result buffer keeps capturing the ALU output in cycles whose strobes target other registers.

Both are provoked by raising RAM read, RAM write, instruction-register write and increment together in one cycle. Three things are then judged through the ports: the opcode shows the word that was read; a later subtraction against that same word yields exactly one, which proves the buffer held the incremented value; and a re-read shows the RAM word unchanged. A separate idle cycle between loading the buffer and reading it shows that the buffer is overwritten without any strobe.

// File: rtl/dp_pkg.sv
package dp_pkg;

   // ALU function code, encoded as {sub, inc}
   typedef enum logic [1:0] {
      ALU_ADD   = 2'b00,
      ALU_INC   = 2'b01,
      ALU_SUB   = 2'b10,
      ALU_UNDEF = 2'b11
   } alu_fn_e;

   // register bank slots
   localparam int REG_MAR  = 0;
   localparam int REG_PC   = 1;
   localparam int REG_ACC  = 2;
   localparam int REG_IR   = 3;
   localparam int REG_ARG  = 4;
   localparam int NUM_REGS = 5;

   // bus sources, index 0 is highest priority
   localparam int SRC_MEM  = 0;
   localparam int SRC_PC   = 1;
   localparam int SRC_ACC  = 2;
   localparam int SRC_IR   = 3;
   localparam int SRC_BUF  = 4;
   localparam int NUM_SRCS = 5;

   localparam int OPC_W = 3;

endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("dp_reg: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/dp_bus_select.sv
module dp_bus_select #(
   parameter int W = 8,
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rd,
   input  logic [W-1:0] src [N],
   output logic [W-1:0] bus
);
   if (N < 1) begin : g_bad_n
      $error("dp_bus_select: N must be positive");
   end

   // walk from lowest priority up so the lowest index wins
   always_comb begin
      bus = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (rd[i]) bus = src[i];
      end
   end

   AST_ONE_READER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd)); // R2
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
   parameter int AW = 5,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("dp_ram: AW out of range");
   end

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[addr] <= wdata;
   end

   assign rdata = store[addr];

   AST_MEM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (!$stable(addr) || rdata == $past(wdata))); // R4
endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_pkg::*;
#(
   parameter int W          = 8,
   parameter bit UNDEF_ZERO = 1'b1
) (
   input  alu_fn_e      fn,
   input  logic [W-1:0] arg,
   input  logic [W-1:0] bus_val,
   output logic [W-1:0] res
);
   logic [W-1:0] undef_val;

   if (UNDEF_ZERO) begin : g_undef_zero
      assign undef_val = '0;
   end else begin : g_undef_arg
      assign undef_val = arg;
   end

   always_comb begin
      unique case (fn)
         ALU_ADD: res = arg + bus_val;
         ALU_INC: res = bus_val + W'(1);
         ALU_SUB: res = arg - bus_val;
         default: res = undef_val;
      endcase
   end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
   import dp_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mem_wr_i,
   input  logic             mem_rd_i,
   input  logic             mar_wr_i,
   input  logic             pc_wr_i,
   input  logic             pc_rd_i,
   input  logic             acc_wr_i,
   input  logic             acc_rd_i,
   input  logic             ir_wr_i,
   input  logic             ir_rd_i,
   input  logic             arg_wr_i,
   input  logic             alu_sub_i,
   input  logic             alu_inc_i,
   input  logic             buf_rd_i,
   output logic             acc_nz_o,
   output logic [OPC_W-1:0] opcode_o
);
   localparam int DATA_W  = ADDR_W + OPC_W;
   localparam int OPC_LSB = ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("acc_datapath: ADDR_W out of range");
   end

   logic [DATA_W-1:0]   bus_val;
   logic [DATA_W-1:0]   reg_q   [NUM_REGS];
   logic [NUM_REGS-1:0] reg_we;
   logic [DATA_W-1:0]   src_val [NUM_SRCS];
   logic [NUM_SRCS-1:0] src_rd;
   logic [DATA_W-1:0]   mem_rdata;
   logic [DATA_W-1:0]   alu_res;
   logic [DATA_W-1:0]   buf_q;
   alu_fn_e             alu_fn;

   // register bank
   always_comb begin
      reg_we          = '0;
      reg_we[REG_MAR] = mar_wr_i;
      reg_we[REG_PC]  = pc_wr_i;
      reg_we[REG_ACC] = acc_wr_i;
      reg_we[REG_IR]  = ir_wr_i;
      reg_we[REG_ARG] = arg_wr_i;
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      dp_reg #(.W(DATA_W)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (reg_we[g]),
         .d     (bus_val),
         .q     (reg_q[g])
      );

      AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         reg_we[g] |=> reg_q[g] == $past(bus_val)); // R3
      AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !reg_we[g] |=> $stable(reg_q[g])); // R3
   end

   // word RAM, low address bits only
   dp_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_wr_i),
      .addr  (reg_q[REG_MAR][ADDR_W-1:0]),
      .wdata (bus_val),
      .rdata (mem_rdata)
   );

   // bus sources in priority order
   always_comb begin
      src_rd          = '0;
      src_rd[SRC_MEM] = mem_rd_i;
      src_rd[SRC_PC]  = pc_rd_i;
      src_rd[SRC_ACC] = acc_rd_i;
      src_rd[SRC_IR]  = ir_rd_i;
      src_rd[SRC_BUF] = buf_rd_i;
      src_val[SRC_MEM] = mem_rdata;
      src_val[SRC_PC]  = reg_q[REG_PC];
      src_val[SRC_ACC] = reg_q[REG_ACC];
      src_val[SRC_IR]  = reg_q[REG_IR];
      src_val[SRC_BUF] = buf_q;
   end

   dp_bus_select #(.W(DATA_W), .N(NUM_SRCS)) u_bus (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (src_rd),
      .src   (src_val),
      .bus   (bus_val)
   );

   // ALU and free-running result buffer
   assign alu_fn = alu_fn_e'({alu_sub_i, alu_inc_i});

   dp_alu #(.W(DATA_W), .UNDEF_ZERO(1'b1)) u_alu (
      .fn      (alu_fn),
      .arg     (reg_q[REG_ARG]),
      .bus_val (bus_val),
      .res     (alu_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_q <= '0;
      else        buf_q <= alu_res;
   end

   assign acc_nz_o = |reg_q[REG_ACC];
   assign opcode_o = reg_q[REG_IR][OPC_LSB +: OPC_W];

   AST_ALU_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (!alu_sub_i && !alu_inc_i) |=>
         buf_q == DATA_W'($past(reg_q[REG_ARG]) + $past(bus_val))); // R5
   AST_ALU_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (!alu_sub_i && alu_inc_i) |=>
         buf_q == DATA_W'($past(bus_val) + DATA_W'(1))); // R6
   AST_ALU_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_sub_i && !alu_inc_i) |=>
         buf_q == DATA_W'($past(reg_q[REG_ARG]) - $past(bus_val))); // R7
   AST_ALU_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_sub_i && alu_inc_i) |=> buf_q == '0); // R8
   AST_NZ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_nz_o) |-> $past(acc_wr_i)); // R11
endmodule

// File: tb/test_acc_datapath.sv
module test_acc_datapath;
   localparam logic [12:0] MWR  = 13'h0001;
   localparam logic [12:0] MRD  = 13'h0002;
   localparam logic [12:0] MARW = 13'h0004;
   localparam logic [12:0] PCW  = 13'h0008;
   localparam logic [12:0] PCR  = 13'h0010;
   localparam logic [12:0] ACCW = 13'h0020;
   localparam logic [12:0] ACCR = 13'h0040;
   localparam logic [12:0] IRW  = 13'h0080;
   localparam logic [12:0] IRR  = 13'h0100;
   localparam logic [12:0] ARGW = 13'h0200;
   localparam logic [12:0] SUB  = 13'h0400;
   localparam logic [12:0] INC  = 13'h0800;
   localparam logic [12:0] BUFR = 13'h1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] st = '0;
   logic        acc_nz;
   logic [2:0]  opcode;
   int          n_checks = 0;
   int          n_fails = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   acc_datapath #(.ADDR_W(5)) i_acc_datapath (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_wr_i  (st[0]),
      .mem_rd_i  (st[1]),
      .mar_wr_i  (st[2]),
      .pc_wr_i   (st[3]),
      .pc_rd_i   (st[4]),
      .acc_wr_i  (st[5]),
      .acc_rd_i  (st[6]),
      .ir_wr_i   (st[7]),
      .ir_rd_i   (st[8]),
      .arg_wr_i  (st[9]),
      .alu_sub_i (st[10]),
      .alu_inc_i (st[11]),
      .buf_rd_i  (st[12]),
      .acc_nz_o  (acc_nz),
      .opcode_o  (opcode)
   );

   // one strobe cycle, driven and sampled at falling edges
   task automatic apply(input logic [12:0] s);
      st = s;
      @(posedge clk);
      @(negedge clk);
      st = '0;
   endtask

   task automatic check_op(input int exp, input string req);
      n_checks++;
      if (opcode !== 3'(exp)) begin
         n_fails++;
         $display("FAIL %s: opcode actual %0d expected %0d", req, opcode, exp);
      end
   endtask

   task automatic check_nz(input bit exp, input string req);
      n_checks++;
      if (acc_nz !== exp) begin
         n_fails++;
         $display("FAIL %s: acc_nz actual %0b expected %0b", req, acc_nz, exp);
      end
   endtask

   task automatic make_buf(input int v);
      apply(SUB | INC);
      repeat (v) apply(BUFR | INC);
   endtask

   task automatic load_acc(input int v);
      make_buf(v);
      apply(BUFR | ACCW);
   endtask

   task automatic load_arg(input int v);
      load_acc(v);
      apply(ACCR | ARGW);
   endtask

   task automatic set_mar(input int a);
      make_buf(a);
      apply(BUFR | MARW);
   endtask

   task automatic store(input int a, input int v);
      load_acc(v);
      set_mar(a);
      apply(ACCR | MWR);
   endtask

   task automatic t_reset;
      check_op(0, "R1");
      check_nz(1'b0, "R1");
   endtask

   task automatic t_inc;
      load_acc(32);
      check_nz(1'b1, "R6");
      apply(ACCR | IRW);
      check_op(1, "R6");
   endtask

   task automatic t_hold;
      apply(PCR);
      check_op(1, "R3 no write strobe");
      apply(PCR | IRW);
      check_op(0, "R3 pc reset value");
      make_buf(160);
      apply(BUFR | PCW);
      apply(PCR | IRW);
      check_op(5, "R3 pc load");
      apply(IRR | ACCW);
      check_nz(1'b1, "R3 ir read");
   endtask

   task automatic t_none;
      load_acc(3);
      check_nz(1'b1, "R11");
      apply(ACCW);
      check_nz(1'b0, "R2 idle bus");
   endtask

   task automatic t_mem;
      store(3, 64);
      set_mar(35);
      apply(MRD | IRW);
      check_op(2, "R4 alias read");
      load_acc(224);
      apply(ACCR);
      apply(MRD | IRW);
      check_op(2, "R4 no write strobe");
      apply(ACCR | MWR);
      set_mar(3);
      apply(MRD | IRW);
      check_op(7, "R4 alias write");
      store(3, 64);
   endtask

   task automatic t_add;
      load_arg(32);
      apply(MRD);
      apply(BUFR | IRW);
      check_op(3, "R5");
      load_arg(224);
      apply(MRD);
      apply(BUFR | IRW);
      check_op(1, "R5 wrap");
   endtask

   task automatic t_sub;
      load_arg(32);
      apply(MRD | SUB);
      apply(BUFR | IRW);
      check_op(7, "R7 borrow");
      load_arg(64);
      check_nz(1'b1, "R11");
      apply(MRD | SUB);
      apply(BUFR | ACCW);
      check_nz(1'b0, "R7 equal");
   endtask

   task automatic t_undef;
      make_buf(96);
      apply(BUFR | ACCW);
      check_nz(1'b1, "R8 setup");
      apply(BUFR | SUB | INC);
      apply(BUFR | ACCW);
      check_nz(1'b0, "R8");
   endtask

   task automatic t_bufcap;
      load_arg(32);
      make_buf(128);
      apply('0);
      apply(BUFR | IRW);
      check_op(1, "R9 idle capture");
   endtask

   task automatic t_opfield;
      make_buf(31);
      apply(BUFR | IRW | ACCW);
      check_op(0, "R10 low bits");
      check_nz(1'b1, "R11");
      make_buf(224);
      apply(BUFR | IRW);
      check_op(7, "R10 top bits");
   endtask

   task automatic t_same;
      set_mar(3);
      apply(IRW);
      check_op(0, "R2 idle bus");
      apply(MRD | IRW | INC | MWR);
      check_op(2, "R4 read with write");
      apply(BUFR | ARGW);
      apply(MRD | SUB);
      apply(BUFR | ACCW);
      check_nz(1'b1, "R9 incremented");
      apply(ACCR | ARGW);
      apply(ACCR | SUB);
      apply(BUFR | ACCW);
      check_nz(1'b0, "R7 self");
      apply(IRW);
      apply(MRD | IRW);
      check_op(2, "R4 word kept");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_inc;
      t_hold;
      t_none;
      t_mem;
      t_add;
      t_sub;
      t_undef;
      t_bufcap;
      t_opfield;
      t_same;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: cycles actual 200000 expected fewer");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule